// File: doc/BRIEF.md
# Parallel Bus Panel Write Engine

This block sends pixel frames to a display panel that keeps its own frame memory, over an asynchronous parallel write bus with an active-low chip select, an active-low write strobe, a register-select line and a data bus. Each pixel goes out in one write cycle. That cycle is shaped by four timing counts set in a configuration register: chip-select setup, strobe setup, strobe active time and data hold. Software sets the timing first and sets the enable bit. It then starts a frame through the trigger register, or arms the block so that a tearing-effect (TE) pulse from the panel starts the frame. Pixels come in on a valid/ready stream, one per write cycle, and a frame is `FRAME_PIXELS` pixels long. When the last pixel's cycle ends, the block sets a frame-done flag. This flag drives the interrupt output when the interrupt is enabled.

Repeated start requests can upset the panel. Any trigger that arrives while a frame is in flight is therefore dropped and is not held for later. The panel timing is meant to run at about twice the nominal pixel rate, so that a frame ends before the next TE pulse.

Two state machines do the work. The frame sequencer has the states FR_IDLE and FR_XFER. It moves FR_IDLE to FR_XFER on an accepted trigger, and FR_XFER to FR_IDLE when the last pixel completes. The cycle generator has the states CY_IDLE, CY_CSS (chip-select setup), CY_WRS (strobe setup), CY_ACT (strobe low) and CY_HLD (data hold). It moves CY_IDLE to the first phase whose count is non-zero when it accepts a pixel, and then on through CSS, WRS, ACT and HLD. Phases with a zero count are skipped, except ACT. It returns from ACT or HLD to CY_IDLE when the pixel is done.

Top module: `pbus_write_engine`

## Requirements
- R1: After reset cs_n and wr_n are 1, rs is 0, pix_ready is 0 and irq is 0. The timing fields reset to CS setup 0, WR setup 0, WR active 1 and WR hold 0, with the interface disabled.
- R2: The timing register is at address 0. CS setup is in bits 19:16, WR setup in bits 15:12, WR active in bits 11:8 and WR hold in bits 7:4. Bit 0 enables the interface, and while bit 0 is 0 no trigger starts a frame.
- R3: A pixel write cycle begins on the clock after the pixel is accepted. cs_n is low for CS setup + WR setup + WR active + WR hold cycles. wr_n goes low once the CS setup and WR setup cycles are over, and stays low for the WR active count. cs_n then returns high for at least one cycle before the next pixel.
- R4: A WR active field of 0 is treated as 1, so the strobe is always low for at least one cycle.
- R5: Writing the trigger register (address 1) with bit 0 (trigger mode) and bit 1 (software command) both set starts exactly one frame of FRAME_PIXELS pixels. The command bit is not stored.
- R6: A software command or TE pulse that arrives while a frame is in progress is ignored and does not start another frame afterwards.
- R7: Completion of a frame sets the done flag. irq equals the done flag AND the interrupt-enable bit (address 3, bit 0). Writing 1 to bit 0 of address 2 clears the flag, and a frame completing in the same cycle takes priority over the clear.
- R8: With trigger-register bit 0 clear, bit 3 (hardware trigger enable) set and bit 4 clear, a rising edge on te_in starts a frame. If bit 31 is clear, only the first such edge after the trigger register is written starts a frame.
- R9: With bit 31 (per-TE) also set, every te_in rising edge seen while idle starts a frame.
- R10: With bit 4 (hardware trigger mask) set, te_in starts no frame.
- R11: db holds the accepted pixel for the whole time cs_n is low, and rs is 1 while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| te_in | input | 1 | Tearing-effect input from panel |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | DATA_W | Pixel stream data |
| pix_ready | output | 1 | Pixel stream ready |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| rs | output | 1 | Register select, high for pixel data |
| db | output | DATA_W | Panel data bus |
| irq | output | 1 | Frame-done interrupt |

## Verification
The hardest case to reach is a trigger that lands in the middle of a frame, as opposed to one that lands just after it. The stimulus issues a second software command and a TE edge while the first frame is still streaming. It then waits well past the end of that frame and checks that the accepted pixel count is still one frame. The single-shot TE arming case is reached the same way: two TE edges, the second one after the first frame has finished, must produce only one frame unless per-TE mode is set.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADR_TIMING = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_TRIG   = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_STATUS = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_IRQEN  = 2'd3;

    typedef struct packed {
        logic [3:0] cs_setup;
        logic [3:0] wr_setup;
        logic [3:0] wr_active;
        logic [3:0] wr_hold;
        logic       enable;
    } timing_t;

    typedef struct packed {
        logic sw_mode;
        logic hw_en;
        logic hw_mask;
        logic per_te;
    } trig_t;

    typedef enum logic [2:0] {
        CY_IDLE, CY_CSS, CY_WRS, CY_ACT, CY_HLD
    } cyc_state_t;

    typedef enum logic {
        FR_IDLE, FR_XFER
    } frame_state_t;
endpackage

// File: rtl/pbw_regs.sv
module pbw_regs
    import pbw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  set_done,
    input  logic                  consume_arm,
    output timing_t               timing,
    output trig_t                 trig,
    output logic                  arm,
    output logic                  sw_cmd,
    output logic                  irq_flag,
    output logic                  irq_en
);
    logic wr_timing, wr_trig, wr_status, wr_irqen;

    always_comb begin
        wr_timing = reg_we && (reg_addr == ADR_TIMING);
        wr_trig   = reg_we && (reg_addr == ADR_TRIG);
        wr_status = reg_we && (reg_addr == ADR_STATUS);
        wr_irqen  = reg_we && (reg_addr == ADR_IRQEN);
        sw_cmd    = wr_trig && reg_wdata[0] && reg_wdata[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing   <= '{cs_setup: 4'd0, wr_setup: 4'd0, wr_active: 4'd1,
                          wr_hold: 4'd0, enable: 1'b0};
            trig     <= '0;
            arm      <= 1'b0;
            irq_flag <= 1'b0;
            irq_en   <= 1'b0;
        end else begin
            if (wr_timing) begin
                timing.cs_setup  <= reg_wdata[19:16];
                timing.wr_setup  <= reg_wdata[15:12];
                timing.wr_active <= reg_wdata[11:8];
                timing.wr_hold   <= reg_wdata[7:4];
                timing.enable    <= reg_wdata[0];
            end
            if (wr_trig) begin
                trig.sw_mode <= reg_wdata[0];
                trig.hw_en   <= reg_wdata[3];
                trig.hw_mask <= reg_wdata[4];
                trig.per_te  <= reg_wdata[31];
                arm          <= reg_wdata[3];
            end else if (consume_arm) begin
                arm <= 1'b0;
            end
            if (set_done)
                irq_flag <= 1'b1;
            else if (wr_status && reg_wdata[0])
                irq_flag <= 1'b0;
            if (wr_irqen)
                irq_en <= reg_wdata[0];
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> irq_flag);  // R7
endmodule

// File: rtl/pbw_frame_ctrl.sv
module pbw_frame_ctrl
    import pbw_pkg::*;
#(
    parameter int FRAME_PIXELS = 16,
    localparam int CNT_W = $clog2(FRAME_PIXELS + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  timing_t timing,
    input  trig_t   trig,
    input  logic    arm,
    input  logic    sw_cmd,
    input  logic    te_in,
    input  logic    pix_done,
    input  logic    cy_idle,
    output logic    busy,
    output logic    frame_done,
    output logic    consume_arm
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_PIXELS - 1);

    frame_state_t state, nstate;
    logic [CNT_W-1:0] count, ncount;
    logic te_q, te_rise, te_start, start;

    always_comb begin
        te_rise  = te_in && !te_q;
        te_start = te_rise && !trig.sw_mode && trig.hw_en && !trig.hw_mask
                   && (trig.per_te || arm);
    end

    always_comb begin
        nstate     = state;
        ncount     = count;
        frame_done = 1'b0;
        start      = 1'b0;
        unique case (state)
            FR_IDLE: begin
                if (timing.enable && (sw_cmd || te_start)) begin
                    start  = 1'b1;
                    nstate = FR_XFER;
                    ncount = '0;
                end
            end
            FR_XFER: begin
                if (pix_done) begin
                    if (count == LAST) begin
                        frame_done = 1'b1;
                        nstate     = FR_IDLE;
                        ncount     = '0;
                    end else begin
                        ncount = count + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            count <= '0;
            te_q  <= 1'b0;
        end else begin
            state <= nstate;
            count <= ncount;
            te_q  <= te_in;
        end
    end

    always_comb begin
        busy        = (state == FR_XFER);
        consume_arm = start && te_start && !trig.per_te;
    end

    AST_START_FROM_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cy_idle));  // R6
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy);  // R5
    AST_DONE_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> pix_done);  // R5
endmodule

// File: rtl/pbw_cycle_gen.sv
module pbw_cycle_gen
    import pbw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_t           timing,
    input  logic              frame_busy,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              pix_done,
    output logic              cy_idle,
    output logic              cs_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] db
);
    cyc_state_t state, nstate;
    logic [3:0] cnt, ncnt, act_eff;
    logic accept;

    always_comb begin
        act_eff = (timing.wr_active == 4'd0) ? 4'd1 : timing.wr_active;
        accept  = pix_ready && pix_valid;
    end

    always_comb begin
        nstate   = state;
        ncnt     = cnt;
        pix_done = 1'b0;
        unique case (state)
            CY_IDLE: begin
                if (accept) begin
                    if (timing.cs_setup != 4'd0) begin
                        nstate = CY_CSS; ncnt = timing.cs_setup - 4'd1;
                    end else if (timing.wr_setup != 4'd0) begin
                        nstate = CY_WRS; ncnt = timing.wr_setup - 4'd1;
                    end else begin
                        nstate = CY_ACT; ncnt = act_eff - 4'd1;
                    end
                end
            end
            CY_CSS: begin
                if (cnt != 4'd0) ncnt = cnt - 4'd1;
                else if (timing.wr_setup != 4'd0) begin
                    nstate = CY_WRS; ncnt = timing.wr_setup - 4'd1;
                end else begin
                    nstate = CY_ACT; ncnt = act_eff - 4'd1;
                end
            end
            CY_WRS: begin
                if (cnt != 4'd0) ncnt = cnt - 4'd1;
                else begin
                    nstate = CY_ACT; ncnt = act_eff - 4'd1;
                end
            end
            CY_ACT: begin
                if (cnt != 4'd0) ncnt = cnt - 4'd1;
                else if (timing.wr_hold != 4'd0) begin
                    nstate = CY_HLD; ncnt = timing.wr_hold - 4'd1;
                end else begin
                    nstate = CY_IDLE; pix_done = 1'b1;
                end
            end
            CY_HLD: begin
                if (cnt != 4'd0) ncnt = cnt - 4'd1;
                else begin
                    nstate = CY_IDLE; pix_done = 1'b1;
                end
            end
            default: nstate = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CY_IDLE;
            cnt   <= '0;
            db    <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
            if (accept) db <= pix_data;
        end
    end

    always_comb begin
        cy_idle   = (state == CY_IDLE);
        pix_ready = frame_busy && cy_idle;
        cs_n      = cy_idle;
        wr_n      = (state != CY_ACT);
    end

    AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);  // R3
    AST_DB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(db));  // R11
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_done |=> cs_n);  // R3
endmodule

// File: rtl/pbus_write_engine.sv
module pbus_write_engine
    import pbw_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int FRAME_PIXELS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              te_in,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rs,
    output logic [DATA_W-1:0] db,
    output logic              irq
);
    timing_t timing;
    trig_t   trig;
    logic arm, sw_cmd, irq_flag, irq_en;
    logic busy, frame_done, consume_arm, pix_done, cy_idle;

    pbw_regs i_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .set_done(frame_done), .consume_arm(consume_arm),
        .timing(timing), .trig(trig), .arm(arm), .sw_cmd(sw_cmd),
        .irq_flag(irq_flag), .irq_en(irq_en)
    );

    pbw_frame_ctrl #(.FRAME_PIXELS(FRAME_PIXELS)) i_frame (
        .clk(clk), .rst_n(rst_n), .timing(timing), .trig(trig), .arm(arm),
        .sw_cmd(sw_cmd), .te_in(te_in), .pix_done(pix_done), .cy_idle(cy_idle),
        .busy(busy), .frame_done(frame_done), .consume_arm(consume_arm)
    );

    pbw_cycle_gen #(.DATA_W(DATA_W)) i_cycle (
        .clk(clk), .rst_n(rst_n), .timing(timing), .frame_busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .pix_done(pix_done), .cy_idle(cy_idle), .cs_n(cs_n), .wr_n(wr_n), .db(db)
    );

    always_comb begin
        rs  = busy;
        irq = irq_flag && irq_en;
    end

    AST_IRQ_NEEDS_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(busy));  // R7
endmodule

// File: tb/test_pbus_write_engine.sv
module test_pbus_write_engine;
    localparam int DW = 16;
    localparam int NPX = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic te_in = 1'b0;
    logic pix_valid = 1'b0;
    logic [DW-1:0] pix_data = '0;
    logic pix_ready, cs_n, wr_n, rs, irq;
    logic [DW-1:0] db;

    always #4 clk = ~clk;

    pbus_write_engine #(.DATA_W(DW), .FRAME_PIXELS(NPX)) i_pbus_write_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .te_in(te_in), .pix_valid(pix_valid),
        .pix_data(pix_data), .pix_ready(pix_ready), .cs_n(cs_n), .wr_n(wr_n),
        .rs(rs), .db(db), .irq(irq)
    );

    int vectors = 0;
    int errors = 0;
    int acc = 0;
    int cs_low = 0;
    int wr_low = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // behavioural reference state
    int m_cs = 0, m_ws = 0, m_act = 1, m_h = 0;
    bit m_en = 0, m_mode = 0, m_hwen = 0, m_mask = 0, m_per = 0, m_arm = 0;
    bit m_irqen = 0, m_flag = 0, m_busy = 0, m_teq = 0;
    int m_pos = -1, m_done = 0;
    logic [DW-1:0] m_data = '0;

    function automatic int act_eff();
        return (m_act == 0) ? 1 : m_act;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cs = 0; m_ws = 0; m_act = 1; m_h = 0; m_en = 0;
            m_mode = 0; m_hwen = 0; m_mask = 0; m_per = 0; m_arm = 0;
            m_irqen = 0; m_flag = 0; m_busy = 0; m_teq = 0;
            m_pos = -1; m_done = 0; m_data = '0;
        end else begin
            bit was_busy, accept, sw, te_ok, done_now, start;
            int total;
            was_busy = m_busy;
            total = m_cs + m_ws + act_eff() + m_h;
            accept = m_busy && (m_pos < 0) && pix_valid;
            done_now = 0;
            if (accept) acc++;
            if (m_pos >= 0) begin
                if (m_pos == total - 1) begin
                    m_pos = -1;
                    m_done++;
                    if (m_done == NPX) begin m_busy = 0; done_now = 1; end
                end else m_pos++;
            end
            if (accept) begin m_pos = 0; m_data = pix_data; end
            sw = reg_we && reg_addr == 2'd1 && reg_wdata[0] && reg_wdata[1];
            te_ok = te_in && !m_teq && !m_mode && m_hwen && !m_mask && (m_per || m_arm);
            start = !was_busy && m_en && (sw || te_ok);
            if (start) begin
                m_busy = 1; m_done = 0;
                if (te_ok && !m_per) m_arm = 0;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: begin
                        m_cs = reg_wdata[19:16]; m_ws = reg_wdata[15:12];
                        m_act = reg_wdata[11:8]; m_h = reg_wdata[7:4];
                        m_en = reg_wdata[0];
                    end
                    2'd1: begin
                        m_mode = reg_wdata[0]; m_hwen = reg_wdata[3];
                        m_mask = reg_wdata[4]; m_per = reg_wdata[31];
                        m_arm = reg_wdata[3];
                    end
                    2'd2: if (reg_wdata[0]) m_flag = 0;
                    default: m_irqen = reg_wdata[0];
                endcase
            end
            if (done_now) m_flag = 1;
            m_teq = te_in;
            if (!cs_n) cs_low++;
            if (!wr_n) wr_low++;
        end
    end

    task automatic cmp(string what, int actv, int expv);
        vectors++;
        if (actv != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, actv, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int total;
            bit e_cs, e_wr;
            total = m_cs + m_ws + act_eff() + m_h;
            e_cs = !(m_pos >= 0);
            e_wr = !(m_pos >= m_cs + m_ws && m_pos < m_cs + m_ws + act_eff() && m_pos >= 0);
            cmp("cs_n", int'(cs_n), int'(e_cs));
            cmp("wr_n", int'(wr_n), int'(e_wr));
            cmp("rs", int'(rs), int'(m_busy));
            cmp("pix_ready", int'(pix_ready), int'(m_busy && m_pos < 0));
            cmp("irq", int'(irq), int'(m_flag && m_irqen));
            if (m_pos >= 0) cmp("db", int'(db), int'(m_data));
            if (total < 1) cmp("total", total, 1);
        end
        pix_data <= DW'(16'hA000 + acc);
    end

    task automatic check(string req, string what, int actv, int expv);
        vectors++;
        if (actv != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic te_pulse();
        @(negedge clk); te_in = 1'b1;
        @(negedge clk); te_in = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        acc = 0; cs_low = 0; wr_low = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", "cs_n reset", int'(cs_n), 1);
        check("R1", "wr_n reset", int'(wr_n), 1);
        check("R1", "rs reset", int'(rs), 0);
        check("R1", "irq reset", int'(irq), 0);
        pix_valid = 1'b1;

        cur_req = "R2";
        clear_counts();
        wr_reg(2'd1, 32'h3);
        wait_cyc(30);
        check("R2", "pixels with interface disabled", acc, 0);

        cur_req = "R1";
        wr_reg(2'd0, 32'h0000_0101); // keep reset timing, enable
        clear_counts();
        wr_reg(2'd1, 32'h3);
        wait_cyc(40);
        check("R1", "cs low cycles, reset timing", cs_low, NPX * 1);
        check("R1", "wr low cycles, reset timing", wr_low, NPX * 1);
        check("R5", "pixels per sw frame", acc, NPX);

        cur_req = "R3";
        wr_reg(2'd0, 32'h0002_1321); // cs 2, ws 1, act 3, hold 2, en
        clear_counts();
        wr_reg(2'd1, 32'h3);
        wait_cyc(4);
        check("R11", "rs high in frame", int'(rs), 1);
        wait_cyc(60);
        check("R3", "cs low cycles", cs_low, NPX * 8);
        check("R3", "wr low cycles", wr_low, NPX * 3);

        cur_req = "R4";
        wr_reg(2'd0, 32'h0001_0011); // cs 1, act 0, hold 1
        clear_counts();
        wr_reg(2'd1, 32'h3);
        wait_cyc(40);
        check("R4", "wr low cycles with active 0", wr_low, NPX * 1);
        check("R4", "cs low cycles with active 0", cs_low, NPX * 3);

        cur_req = "R6";
        wr_reg(2'd0, 32'h0002_1321);
        clear_counts();
        wr_reg(2'd1, 32'h3);
        wait_cyc(6);
        wr_reg(2'd1, 32'h3);
        wr_reg(2'd1, 32'h8000_0008);
        te_pulse();
        wait_cyc(100);
        check("R6", "pixels after mid-frame triggers", acc, NPX);

        cur_req = "R7";
        wr_reg(2'd3, 32'h1);
        @(negedge clk);
        check("R7", "irq after done with enable", int'(irq), 1);
        wr_reg(2'd2, 32'h1);
        @(negedge clk);
        check("R7", "irq after clear", int'(irq), 0);

        cur_req = "R8";
        clear_counts();
        wr_reg(2'd1, 32'h8);
        te_pulse();
        wait_cyc(60);
        te_pulse();
        wait_cyc(60);
        check("R8", "pixels from two TE, single shot", acc, NPX);
        check("R7", "irq raised by TE frame", int'(irq), 1);
        wr_reg(2'd2, 32'h1);

        cur_req = "R9";
        clear_counts();
        wr_reg(2'd1, 32'h8000_0008);
        te_pulse();
        wait_cyc(60);
        te_pulse();
        wait_cyc(60);
        check("R9", "pixels from two TE, per-TE", acc, 2 * NPX);

        cur_req = "R10";
        clear_counts();
        wr_reg(2'd1, 32'h8000_0018);
        te_pulse();
        wait_cyc(40);
        check("R10", "pixels with TE masked", acc, 0);

        cur_req = "R11";
        wr_reg(2'd0, 32'h0001_2131);
        wr_reg(2'd1, 32'h3);
        wait_cyc(60);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog %s: actual 0 expected 1", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule